// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Flow Control

This block moves 8-bit frames in both directions at once over a data-out line, a data-in line and a shared transfer clock. The transfer clock either comes from an internal divider or arrives on an external clock pin. Each transfer is started from the transmit side. A byte written to the transmit holding buffer moves into the transmit shift register as soon as that register is free. The frame then shifts out least significant bit first, and the same number of bits is shifted in from the data-in line. To only receive, software writes a dummy byte.

The CPU side has three parts: a write port into the transmit holding buffer, a read strobe for the receive buffer, and sticky transmit and receive request flags, each with its own clear strobe. There is also an overrun flag. One handshake input and one handshake output carry flow control. In clear-to-send mode, a high handshake input holds the generated clock at a bit boundary. In request-to-send mode, the handshake output is high from the first bit of an arriving frame until the receive buffer is read.

Top module: `sync_serial_port`

## Requirements
- R1: After reset: `sclk_o` high with `cfg_pol`=0, `sclk_oe` high, `txd` high, `tx_empty` high, and `tx_irq`, `rx_irq`, `overrun`, `hs_o` low.
- R2: In internal-clock mode one transfer-clock period is 2(`cfg_div`+1) count-source ticks. `cfg_src` selects the count source: 0 is every clock, 1 is every 8th clock, 2 is every 32nd clock, and 3 is each `sub_tick` pulse.
- R3: A frame is 8 bits sent on `txd` and received from `rxd`, both least significant bit first. The transmit and receive bytes are independent.
- R4: With `cfg_pol`=0 the clock idles high, `txd` changes on falling edges and `rxd` is sampled on rising edges. With `cfg_pol`=1 every edge is inverted and the clock idles low.
- R5: The move from the holding buffer into the shift register sets `tx_irq`. The flag stays set until `tx_irq_clr`. A byte queued during a frame starts right after that frame. `tx_empty` is high only when both the buffer and the shift register are idle.
- R6: After the 8th sampling edge the received byte appears on `rx_data` and `rx_irq` is set until `rx_irq_clr`. With `cfg_rx_en`=0 neither changes.
- R7: If a frame completes while the receive buffer is still unread, `overrun` is set and the older byte is kept. `overrun` stays set until `err_clr`.
- R8: With `cfg_fc_en`=1 and `cfg_fc_rts`=0, a high `hs_i` stops clock edges before the next bit, and before the first bit of a frame. The frame resumes intact once `hs_i` returns low.
- R9: With `cfg_fc_en`=1 and `cfg_fc_rts`=1, `hs_o` rises at the first bit of a received frame and falls at `rx_rd`. In other modes `hs_o` stays low.
- R10: Clearing `cfg_tx_en` lets the current frame finish. No later frame starts, and a queued byte stays queued until `cfg_tx_en` is set again.
- R11: With `cfg_ext_clk`=1, `sclk_oe` is low and shifting follows the edges of `sclk_i` after a two-flop synchronizer, under the same polarity rule as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_pol | input | 1 | Clock polarity select |
| cfg_ext_clk | input | 1 | 1: clock from `sclk_i`, 0: internal divider |
| cfg_fc_en | input | 1 | Flow control enable |
| cfg_fc_rts | input | 1 | 1: request-to-send output, 0: clear-to-send input |
| cfg_src | input | 2 | Count source select |
| cfg_div | input | 8 | Divider setting n |
| sub_tick | input | 1 | Sub-clock count pulse |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| tx_irq | output | 1 | Transmit buffer empty request |
| tx_irq_clr | input | 1 | Clear strobe for `tx_irq` |
| rx_irq | output | 1 | Receive complete request |
| rx_irq_clr | input | 1 | Clear strobe for `rx_irq` |
| overrun | output | 1 | Overrun error flag |
| err_clr | input | 1 | Clear strobe for `overrun` |
| tx_empty | output | 1 | Buffer and shift register both idle |
| sclk_o | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Clock output enable |
| sclk_i | input | 1 | External transfer clock |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| hs_i | input | 1 | Clear-to-send input |
| hs_o | output | 1 | Request-to-send output |

## Verification
The hardest state to reach from the ports is a pause in the middle of a frame: the clock must be held at a bit boundary with exactly the right bits already shifted. The bench's slave model counts sampling edges. It raises `hs_i` just after the third one, then checks that no clock edge appears for a long window and that the frame still completes with both bytes correct. Overrun and the request flag for a queued byte need a second byte queued while the first is still shifting. The bench writes back-to-back and holds off the receive-buffer read until both frames are over.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'd0,
        SRC_DIV8  = 2'd1,
        SRC_DIV32 = 2'd2,
        SRC_SUB   = 2'd3
    } src_e;

    localparam int PRE_W = 5;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_i,
    input  logic [DIV_W-1:0] div_n_i,
    input  logic             sub_tick_i,
    input  logic             pol_i,
    input  logic             ext_i,
    input  logic             ext_clk_s_i,
    input  logic             run_i,
    input  logic             hold_i,
    output logic             launch_o,
    output logic             capture_o,
    output logic             sclk_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic             lvl;
        logic             eprev;
    } clk_st_t;

    clk_st_t st_q, st_d;
    logic    tick;
    logic    wrap;
    logic    run_int;
    logic    int_launch, int_capture;
    logic    ext_lvl;

    assign run_int = run_i && !ext_i;
    assign ext_lvl = ext_clk_s_i ^ pol_i;

    always_comb begin
        unique case (src_e'(src_i))
            SRC_DIV1:  tick = 1'b1;
            SRC_DIV8:  tick = (st_q.pre[2:0] == 3'b111);
            SRC_DIV32: tick = (st_q.pre == {PRE_W{1'b1}});
            default:   tick = sub_tick_i;
        endcase
    end

    assign wrap        = tick && (st_q.div == div_n_i);
    assign int_launch  = run_int && wrap && st_q.lvl && !hold_i;
    assign int_capture = run_int && wrap && !st_q.lvl;

    always_comb begin
        st_d       = st_q;
        st_d.pre   = st_q.pre + 1'b1;
        st_d.eprev = ext_lvl;
        if (!run_int) begin
            st_d.div = '0;
            st_d.lvl = 1'b1;
        end else if (tick) begin
            if (wrap) begin
                if (st_q.lvl && hold_i) begin
                    st_d.div = st_q.div;
                end else begin
                    st_d.div = '0;
                    st_d.lvl = !st_q.lvl;
                end
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pre: '0, div: '0, lvl: 1'b1, eprev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign launch_o  = ext_i ? (st_q.eprev && !ext_lvl) : int_launch;
    assign capture_o = ext_i ? (!st_q.eprev && ext_lvl) : int_capture;
    assign sclk_o    = st_q.lvl ^ pol_i;

    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_int |=> st_q.lvl);

    p_pause_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_int && hold_i && st_q.lvl) |=> st_q.lvl);

    p_edges_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_o && capture_o));

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_rd_i,
    input  logic              tx_irq_clr_i,
    input  logic              rx_irq_clr_i,
    input  logic              err_clr_i,
    input  logic              launch_i,
    input  logic              capture_i,
    input  logic              rxd_i,
    output logic              active_o,
    output logic              txd_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              tx_irq_o,
    output logic              rx_irq_o,
    output logic              overrun_o,
    output logic              tx_empty_o,
    output logic              rts_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] tbuf;
        logic              tfull;
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-1:0] rsh;
        logic [CNT_W-1:0]  bcnt;
        logic              active;
        logic              txd;
        logic [DATA_W-1:0] rbuf;
        logic              rfull;
        logic              tx_irq;
        logic              rx_irq;
        logic              ovr;
        logic              rts;
    } eng_st_t;

    eng_st_t st_q, st_d;
    logic [DATA_W-1:0] rx_next;

    assign rx_next = {rxd_i, st_q.rsh[DATA_W-1:1]};

    always_comb begin
        st_d = st_q;

        if (launch_i && st_q.active) begin
            st_d.txd = st_q.tsh[0];
            st_d.tsh = {1'b0, st_q.tsh[DATA_W-1:1]};
            if (st_q.bcnt == '0 && rx_en_i) begin
                st_d.rts = 1'b1;
            end
        end

        if (tx_irq_clr_i) st_d.tx_irq = 1'b0;
        if (rx_irq_clr_i) st_d.rx_irq = 1'b0;
        if (err_clr_i)    st_d.ovr    = 1'b0;

        if (rx_rd_i) begin
            st_d.rfull = 1'b0;
            st_d.rts   = 1'b0;
        end

        if (capture_i && st_q.active) begin
            st_d.rsh  = rx_next;
            st_d.bcnt = st_q.bcnt + 1'b1;
            if (st_q.bcnt == LAST_BIT) begin
                st_d.active = 1'b0;
                st_d.bcnt   = '0;
                if (rx_en_i) begin
                    if (st_d.rfull) begin
                        st_d.ovr = 1'b1;
                    end else begin
                        st_d.rbuf   = rx_next;
                        st_d.rfull  = 1'b1;
                        st_d.rx_irq = 1'b1;
                    end
                end
            end
        end

        if (tx_wr_i) begin
            st_d.tbuf  = tx_data_i;
            st_d.tfull = 1'b1;
        end

        if (!st_d.active && st_d.tfull && tx_en_i) begin
            st_d.tsh    = st_d.tbuf;
            st_d.tfull  = 1'b0;
            st_d.active = 1'b1;
            st_d.bcnt   = '0;
            st_d.tx_irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o   = st_q.active;
    assign txd_o      = st_q.txd;
    assign rx_data_o  = st_q.rbuf;
    assign tx_irq_o   = st_q.tx_irq;
    assign rx_irq_o   = st_q.rx_irq;
    assign overrun_o  = st_q.ovr;
    assign tx_empty_o = !st_q.tfull && !st_q.active;
    assign rts_o      = st_q.rts;

    p_load_raises_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> st_q.tx_irq);

    p_overrun_keeps_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $stable(st_q.rbuf));

    p_rx_flag_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rx_irq) |-> st_q.rfull);

    p_read_drops_rts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_i |=> !st_q.rts);

    p_disabled_rx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en_i && !rx_rd_i) |=> $stable(st_q.rbuf));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_pol,
    input  logic              cfg_ext_clk,
    input  logic              cfg_fc_en,
    input  logic              cfg_fc_rts,
    input  logic [1:0]        cfg_src,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              sub_tick,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_irq,
    input  logic              tx_irq_clr,
    output logic              rx_irq,
    input  logic              rx_irq_clr,
    output logic              overrun,
    input  logic              err_clr,
    output logic              tx_empty,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sclk_i,
    output logic              txd,
    input  logic              rxd,
    input  logic              hs_i,
    output logic              hs_o
);
    logic [2:0] sync_in, sync_out;
    logic       ext_clk_s, rxd_s, cts_s;
    logic       launch, capture, active, rts_raw, hold, rxd_use;

    assign sync_in = {hs_i, rxd, sclk_i};

    ssp_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    assign ext_clk_s = sync_out[0];
    assign rxd_s     = sync_out[1];
    assign cts_s     = sync_out[2];
    assign hold      = cfg_fc_en && !cfg_fc_rts && cts_s;
    assign rxd_use   = cfg_ext_clk ? rxd_s : rxd;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (cfg_src),
        .div_n_i     (cfg_div),
        .sub_tick_i  (sub_tick),
        .pol_i       (cfg_pol),
        .ext_i       (cfg_ext_clk),
        .ext_clk_s_i (ext_clk_s),
        .run_i       (active),
        .hold_i      (hold),
        .launch_o    (launch),
        .capture_o   (capture),
        .sclk_o      (sclk_o)
    );

    ssp_engine #(.DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en_i      (cfg_tx_en),
        .rx_en_i      (cfg_rx_en),
        .tx_wr_i      (tx_wr),
        .tx_data_i    (tx_data),
        .rx_rd_i      (rx_rd),
        .tx_irq_clr_i (tx_irq_clr),
        .rx_irq_clr_i (rx_irq_clr),
        .err_clr_i    (err_clr),
        .launch_i     (launch),
        .capture_i    (capture),
        .rxd_i        (rxd_use),
        .active_o     (active),
        .txd_o        (txd),
        .rx_data_o    (rx_data),
        .tx_irq_o     (tx_irq),
        .rx_irq_o     (rx_irq),
        .overrun_o    (overrun),
        .tx_empty_o   (tx_empty),
        .rts_o        (rts_raw)
    );

    assign sclk_oe = !cfg_ext_clk;
    assign hs_o    = cfg_fc_en && cfg_fc_rts && rts_raw;

    p_ext_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext_clk |-> !sclk_oe);

    p_hs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_fc_en && cfg_fc_rts) |-> !hs_o);

endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       cfg_tx_en = 1'b1, cfg_rx_en = 1'b1, cfg_pol = 1'b0, cfg_ext_clk = 1'b0;
    logic       cfg_fc_en = 1'b0, cfg_fc_rts = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic [7:0] cfg_div = 8'd0;
    logic       sub_tick = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, tx_irq_clr = 1'b0, rx_irq_clr = 1'b0, err_clr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic       sclk_i = 1'b1, hs_i = 1'b0;
    logic [7:0] rx_data;
    logic       tx_irq, rx_irq, overrun, tx_empty, sclk_o, sclk_oe, txd, hs_o;
    logic       slv_rxd = 1'b0, ext_rxd = 1'b0, ext_mode = 1'b0, rxd;

    assign rxd = ext_mode ? ext_rxd : slv_rxd;

    sync_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_pol(cfg_pol), .cfg_ext_clk(cfg_ext_clk), .cfg_fc_en(cfg_fc_en),
        .cfg_fc_rts(cfg_fc_rts), .cfg_src(cfg_src), .cfg_div(cfg_div),
        .sub_tick(sub_tick), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_data(rx_data), .tx_irq(tx_irq), .tx_irq_clr(tx_irq_clr),
        .rx_irq(rx_irq), .rx_irq_clr(rx_irq_clr), .overrun(overrun),
        .err_clr(err_clr), .tx_empty(tx_empty), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sclk_i(sclk_i), .txd(txd), .rxd(rxd), .hs_i(hs_i), .hs_o(hs_o)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int st_cnt = 0;
    always @(negedge clk) begin
        st_cnt   <= (st_cnt == 2) ? 0 : st_cnt + 1;
        sub_tick <= (st_cnt == 2);
    end

    // slave model on the internal clock
    logic        mon_en = 1'b0, per_en = 1'b0;
    logic        prev_lv = 1'b1;
    logic [31:0] slv_pat = '0;
    logic [7:0]  slv_got = '0;
    int          slv_launch = 0, slv_caps = 0, edge_cnt = 0, last_cap = 0, exp_per = 0;

    always @(negedge clk) begin
        logic lv;
        lv = sclk_o ^ cfg_pol;
        if (mon_en && sclk_oe) begin
            if (prev_lv && !lv) begin
                slv_rxd    <= slv_pat[slv_launch % 32];
                slv_launch <= slv_launch + 1;
                edge_cnt   <= edge_cnt + 1;
            end
            if (!prev_lv && lv) begin
                slv_got  <= {txd, slv_got[7:1]};
                edge_cnt <= edge_cnt + 1;
                if (per_en && (slv_caps % 8) != 0) begin
                    n_chk++;
                    if (cyc - last_cap != exp_per) begin
                        n_bad++;
                        $display("FAIL R2: clock period %0d expected %0d", cyc - last_cap, exp_per);
                    end
                end
                last_cap <= cyc;
                slv_caps <= slv_caps + 1;
            end
        end
        prev_lv <= lv;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic write_tx(input logic [7:0] b);
        @(negedge clk) begin tx_data = b; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
    endtask

    task automatic wait_caps(input int target, input string req);
        int t;
        t = 0;
        while (slv_caps < target && t < 30000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 30000) begin
            n_chk++; n_bad++;
            $display("FAIL %s: timeout waiting for edges actual %0d expected %0d", req, slv_caps, target);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic pol, input logic [1:0] src, input logic [7:0] div);
        @(negedge clk) mon_en = 1'b0;
        cfg_pol = pol; cfg_src = src; cfg_div = div;
        exp_per = 2 * (div + 1) * ((src == 0) ? 1 : (src == 1) ? 8 : (src == 2) ? 32 : 3);
        repeat (3) @(negedge clk);
        mon_en = 1'b1;
    endtask

    task automatic clear_all();
        pulse(rx_rd); pulse(rx_irq_clr); pulse(tx_irq_clr); pulse(err_clr);
    endtask

    // one frame through the internal clock, both directions checked
    task automatic xfer(input logic [7:0] tb, input logic [7:0] rb, input string req);
        slv_pat = {24'd0, rb}; slv_launch = 0; slv_caps = 0;
        write_tx(tb);
        wait_caps(8, req);
        check({req, " rx byte"}, rx_data, rb);
        check({req, " tx byte"}, slv_got, tb);
        check({req, " rx flag"}, rx_irq, 1);
        clear_all();
    endtask

    task automatic ext_xfer(input logic pol, input logic [7:0] tb, input logic [7:0] rb);
        logic [7:0] got;
        got = '0;
        @(negedge clk) begin mon_en = 1'b0; cfg_pol = pol; cfg_ext_clk = 1'b1; ext_mode = 1'b1; sclk_i = ~pol; end
        repeat (8) @(negedge clk);
        check("R11 clock not driven", sclk_oe, 0);
        write_tx(tb);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_i = pol; ext_rxd = rb[i];
            repeat (8) @(negedge clk);
            got = {txd, got[7:1]};
            sclk_i = ~pol;
            repeat (8) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        check("R11 ext rx byte", rx_data, rb);
        check("R11 ext tx byte", got, tb);
        clear_all();
        @(negedge clk) begin cfg_ext_clk = 1'b0; ext_mode = 1'b0; end
    endtask

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 sclk idle", sclk_o, 1);
        check("R1 sclk_oe", sclk_oe, 1);
        check("R1 txd", txd, 1);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 flags", {tx_irq, rx_irq, overrun, hs_o}, 0);

        // R3 R4: exhaustive byte sweep, both polarities
        for (int p = 0; p < 2; p++) begin
            set_cfg(p[0], 2'd0, 8'd0);
            per_en = 1'b1;
            for (int b = 0; b < 256; b++) begin
                xfer(b[7:0], 8'(b * 37 + 11), "R3");
            end
        end
        // R2: divider and count source sweep
        begin
            logic [7:0] divs [6] = '{8'd1, 8'd2, 8'd3, 8'd7, 8'd64, 8'd255};
            for (int i = 0; i < 6; i++) begin
                set_cfg(1'b0, 2'd0, divs[i]);
                xfer(8'hA5 ^ divs[i], 8'h5A + divs[i], "R2");
            end
        end
        for (int s = 1; s < 4; s++) begin
            set_cfg(1'b1, s[1:0], 8'd1);
            xfer(8'h96, 8'h69, "R2 src");
        end
        set_cfg(1'b0, 2'd0, 8'd3);

        // R5 R7: back-to-back frames, unread buffer
        slv_pat = {16'd0, 8'hA5, 8'h3C}; slv_launch = 0; slv_caps = 0;
        write_tx(8'h11);
        check("R5 irq on move", tx_irq, 1);
        write_tx(8'h22);
        pulse(tx_irq_clr);
        check("R5 irq cleared", tx_irq, 0);
        check("R5 not empty", tx_empty, 0);
        wait_caps(8, "R5");
        check("R5 irq on second move", tx_irq, 1);
        check("R5 busy second", tx_empty, 0);
        wait_caps(16, "R7");
        check("R5 both idle", tx_empty, 1);
        check("R7 overrun", overrun, 1);
        check("R7 older byte kept", rx_data, 8'h3C);
        check("R5 second byte out", slv_got, 8'h22);
        pulse(err_clr);
        check("R7 overrun cleared", overrun, 0);
        clear_all();

        // R6: receive disabled
        cfg_rx_en = 1'b0;
        slv_pat = 32'hC3; slv_launch = 0; slv_caps = 0;
        write_tx(8'h44);
        wait_caps(8, "R6");
        check("R6 no rx flag", rx_irq, 0);
        check("R6 buffer unchanged", rx_data, 8'h3C);
        cfg_rx_en = 1'b1;
        clear_all();

        // R10: transmit disable mid-frame
        slv_launch = 0; slv_caps = 0; slv_pat = 32'h0;
        write_tx(8'h5E);
        write_tx(8'hE5);
        while (slv_caps < 2) @(negedge clk);
        cfg_tx_en = 1'b0;
        wait_caps(8, "R10");
        repeat (200) @(negedge clk);
        check("R10 stops after frame", slv_caps, 8);
        check("R10 byte queued", tx_empty, 0);
        check("R10 first byte", slv_got, 8'h5E);
        cfg_tx_en = 1'b1;
        wait_caps(16, "R10");
        check("R10 resumes", slv_got, 8'hE5);
        clear_all();

        // R8: clear-to-send pause
        cfg_fc_en = 1'b1; cfg_fc_rts = 1'b0; per_en = 1'b0;
        hs_i = 1'b1;
        slv_pat = 32'h7B; slv_launch = 0; slv_caps = 0;
        write_tx(8'hD2);
        e0 = edge_cnt;
        repeat (100) @(negedge clk);
        check("R8 no start", edge_cnt, e0);
        hs_i = 1'b0;
        while (slv_caps < 3) @(negedge clk);
        hs_i = 1'b1;
        repeat (12) @(negedge clk);
        e0 = edge_cnt;
        repeat (120) @(negedge clk);
        check("R8 paused", edge_cnt, e0);
        check("R9 low in cts mode", hs_o, 0);
        hs_i = 1'b0;
        wait_caps(8, "R8");
        check("R8 rx after pause", rx_data, 8'h7B);
        check("R8 tx after pause", slv_got, 8'hD2);
        clear_all();

        // R9: request-to-send
        cfg_fc_rts = 1'b1;
        check("R9 idle low", hs_o, 0);
        slv_pat = 32'h19; slv_launch = 0; slv_caps = 0;
        write_tx(8'h91);
        while (slv_caps < 1) @(negedge clk);
        check("R9 high in frame", hs_o, 1);
        wait_caps(8, "R9");
        check("R9 high unread", hs_o, 1);
        pulse(rx_rd);
        check("R9 low after read", hs_o, 0);
        clear_all();
        cfg_fc_en = 1'b0; cfg_fc_rts = 1'b0; per_en = 1'b1;

        // R11: external clock, both polarities
        ext_xfer(1'b0, 8'hB4, 8'h2D);
        ext_xfer(1'b1, 8'h0F, 8'hF1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        while (cyc < 190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule